// File: doc/BRIEF.md
# MSB-First Bit Search Unit

This unit accepts a 32-bit data word together with a two-bit search mode and reports where the first qualifying bit lies. The scan starts at the most significant bit and moves down. Three criteria are available: the first bit equal to 0, the first bit equal to 1, and the first bit whose value differs from the bit scanned just before it.

Software or a neighbouring block presents the word and the mode on a write strobe. On the next clock edge the registered result appears: a position counted from the top of the word, so the MSB is position 0 and the LSB is position 31. A separate flag marks a word in which nothing qualified. The result stays unchanged until the next write.

Top module: `bit_search_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the result is cleared: `rd_pos` becomes 32 and `rd_none` becomes 1.
- R2: With mode 2'b00, `rd_pos` is the scan index of the first 0 bit. Scan index k refers to data bit 31-k.
- R3: With mode 2'b01, `rd_pos` is the scan index of the first 1 bit.
- R4: With mode 2'b10, `rd_pos` is the smallest scan index k (k ≥ 1) at which data bit 31-k differs from data bit 32-k. Index 0 is therefore never reported in this mode.
- R5: When no bit qualifies, `rd_pos` is 32 and `rd_none` is 1. Otherwise `rd_none` is 0 and `rd_pos` lies in 0..31.
- R6: Mode 2'b11 gives exactly the result of mode 2'b00.
- R7: The result is loaded on the rising edge at which `wr_en` is high. When `wr_en` is low, it holds its value whatever `wr_mode` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe; starts a search |
| wr_mode | input | 2 | Search criterion: 00 zero, 01 one, 10 change, 11 as zero |
| wr_data | input | 32 | Word to be searched |
| rd_pos | output | 6 | Registered result position, counted from the MSB (32 = none) |
| rd_none | output | 1 | Registered flag: no bit met the criterion |

## Verification
The case hardest to reach from the ports is a change search where the only transition sits at the lowest bit pair. It stands beside words that are fully uniform, where the answer must be "none" even though every other mode would find a bit. The bench reaches these cases on purpose. It writes words made of a run of ones above a run of zeros, and the reverse, for every split point from 0 to 32, and also walking single bits. Every word goes through all four mode codes, and pseudo-random words fill in the rest. Hold behaviour is provoked by changing data and mode while the strobe is low.

// File: rtl/bsu_pkg.sv
// Package: shared types for the bit search unit.
// Assumes: the mode field is two bits wide, and its code values are fixed by the interface.
package bsu_pkg;

    // Search criterion as carried on the write port
    typedef enum logic [1:0] {
        SRCH_ZERO   = 2'b00,
        SRCH_ONE    = 2'b01,
        SRCH_CHANGE = 2'b10,
        SRCH_RSVD   = 2'b11
    } srch_mode_e;

endpackage

// File: rtl/bsu_hit_gen.sv
// Module: bsu_hit_gen
// Builds a per-bit qualification vector from the data word and the criterion.
// Bit i of hit_vec is set when data bit i qualifies under the selected mode.
// Assumes: the reserved code is handled as zero-detect; in change mode the top
// bit has no predecessor and so never qualifies.
module bsu_hit_gen
    import bsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  srch_mode_e          mode,
    input  logic [DATA_W-1:0]   data,
    output logic [DATA_W-1:0]   hit_vec
);

    logic [DATA_W-1:0] diff_vec;

    // Change vector: each bit compared with the bit above it
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W - 1; gi++) begin : g_diff
            assign diff_vec[gi] = data[gi] ^ data[gi+1];
        end
    endgenerate
    assign diff_vec[DATA_W-1] = 1'b0;

    // Criterion select
    always_comb begin
        unique case (mode)
            SRCH_ONE:    hit_vec = data;
            SRCH_CHANGE: hit_vec = diff_vec;
            default:     hit_vec = ~data;
        endcase
    end

endmodule

// File: rtl/bsu_lead_find.sv
// Module: bsu_lead_find
// Priority encoder that finds the highest set bit of a vector and returns its
// distance from the MSB. Reports DATA_W and found=0 for an all-zero vector.
// Assumes: POS_W is wide enough to hold DATA_W.
module bsu_lead_find #(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] vec,
    output logic              found,
    output logic [POS_W-1:0]  pos
);

    // Upward sweep: the last set bit seen is the highest one
    always_comb begin
        found = 1'b0;
        pos   = POS_W'(DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                pos   = POS_W'(DATA_W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/bsu_result_reg.sv
// Module: bsu_result_reg
// Holds the search result. It loads on a write strobe and keeps its value otherwise.
// Assumes: synchronous active-low reset; the reset value is the "none" result.
module bsu_result_reg #(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             found,
    input  logic [POS_W-1:0] pos_in,
    output logic [POS_W-1:0] pos_q,
    output logic             none_q
);

    // Result storage with reset and load enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= POS_W'(DATA_W);
            none_q <= 1'b1;
        end else if (load) begin
            pos_q  <= pos_in;
            none_q <= ~found;
        end
    end

endmodule

// File: rtl/bit_search_unit.sv
// Module: bit_search_unit (top)
// MSB-first bit search: the first zero, the first one or the first change
// in a data word. The result is registered one edge after the write strobe.
// Assumes: the inputs are synchronous to clk; rst_n is synchronous and active low.
module bit_search_unit
    import bsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_mode,
    input  logic [DATA_W-1:0] wr_data,
    output logic [POS_W-1:0]  rd_pos,
    output logic              rd_none
);

    srch_mode_e        mode_sel;
    logic [DATA_W-1:0] hit_vec;
    logic              hit_found;
    logic [POS_W-1:0]  hit_pos;

    // Raw mode code mapped onto the enumerated type
    assign mode_sel = srch_mode_e'(wr_mode);

    bsu_hit_gen #(.DATA_W(DATA_W)) u_hit (
        .mode    (mode_sel),
        .data    (wr_data),
        .hit_vec (hit_vec)
    );

    bsu_lead_find #(.DATA_W(DATA_W), .POS_W(POS_W)) u_find (
        .vec   (hit_vec),
        .found (hit_found),
        .pos   (hit_pos)
    );

    bsu_result_reg #(.DATA_W(DATA_W), .POS_W(POS_W)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_en),
        .found  (hit_found),
        .pos_in (hit_pos),
        .pos_q  (rd_pos),
        .none_q (rd_none)
    );

endmodule

// File: rtl/bsu_checker.sv
// Module: bsu_checker
// Temporal checks on the ports of bit_search_unit, attached by bind.
// Assumes: the same parameters as the top module.
module bsu_checker #(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_mode,
    input logic [DATA_W-1:0] wr_data,
    input logic [POS_W-1:0]  rd_pos,
    input logic              rd_none
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (rd_pos == POS_W'(DATA_W) && rd_none)); // R1

    AST_ZERO_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_mode) == 2'b00 && !$past(wr_data[DATA_W-1]))
        |-> (rd_pos == '0)); // R2

    AST_ONE_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_mode) == 2'b01 && $past(wr_data[DATA_W-1]))
        |-> (rd_pos == '0)); // R3

    AST_CHANGE_NEVER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_mode) == 2'b10)
        |-> (rd_pos != '0)); // R4

    AST_FLAG_TRACKS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_none == (rd_pos == POS_W'(DATA_W))); // R5

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pos <= POS_W'(DATA_W)); // R5

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> ($stable(rd_pos) && $stable(rd_none))); // R7

endmodule

bind bit_search_unit bsu_checker #(.DATA_W(DATA_W), .POS_W(POS_W)) u_bsu_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_mode (wr_mode),
    .wr_data (wr_data),
    .rd_pos  (rd_pos),
    .rd_none (rd_none)
);

// File: tb/tb_bit_search_unit.sv
`timescale 1ns/1ps
// Bench: sweeps structured and pseudo-random words through all four mode codes.
// Expected results are computed arithmetically from the requirements.
module tb_bit_search_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_mode = 2'b00;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_pos;
    logic        rd_none;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bit_search_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
        .wr_data(wr_data), .rd_pos(rd_pos), .rd_none(rd_none)
    );

    // Reference search from the requirement text
    function automatic int ref_pos(input logic [1:0] m, input logic [31:0] d);
        for (int k = 0; k < 32; k++) begin
            logic b;
            b = d[31-k];
            if (m == 2'b01) begin
                if (b) return k;
            end else if (m == 2'b10) begin
                if (k > 0 && b != d[32-k]) return k;
            end else begin
                if (!b) return k;
            end
        end
        return 32;
    endfunction

    task automatic check(input string tag, input int exp_pos, input bit exp_none);
        n_chk++;
        if (rd_pos != 6'(exp_pos) || rd_none != exp_none) begin
            n_bad++;
            $display("FAIL %s pos=%0d exp=%0d none=%0b exp=%0b", tag, rd_pos, exp_pos,
                     rd_none, exp_none);
        end
    endtask

    task automatic do_search(input logic [1:0] m, input logic [31:0] d);
        int    e;
        string tag;
        @(negedge clk);
        wr_en = 1'b1; wr_mode = m; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        e = ref_pos(m, d);
        case (m)
            2'b00:   tag = "R2";
            2'b01:   tag = "R3";
            2'b10:   tag = "R4";
            default: tag = "R6";
        endcase
        if (e == 32) tag = {tag, "/R5"};
        check(tag, e, e == 32);
    endtask

    task automatic all_modes(input logic [31:0] d);
        for (int m = 0; m < 4; m++) do_search(2'(m), d);
    endtask

    initial begin
        logic [31:0] lfsr;
        int          e;
        repeat (3) @(negedge clk);
        check("R1", 32, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32, 1'b1);

        // Runs of ones over zeros and the reverse, every split point
        for (int p = 0; p <= 32; p++) begin
            logic [31:0] w;
            w = (p == 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> p);
            all_modes(w);
            all_modes(~w);
        end
        // Walking one and walking zero
        for (int p = 0; p < 32; p++) begin
            all_modes(32'h1 << p);
            all_modes(~(32'h1 << p));
        end
        // Change only at the lowest pair
        all_modes(32'h0000_0001);
        all_modes(32'hFFFF_FFFE);

        // Pseudo-random words
        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 200; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            all_modes(lfsr);
        end

        // Hold while the strobe is low
        do_search(2'b01, 32'h0010_0000);
        e = ref_pos(2'b01, 32'h0010_0000);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            wr_en = 1'b0; wr_mode = 2'(n); wr_data = 32'h8000_0000 >> n;
            @(negedge clk);
            check("R7", e, 1'b0);
        end

        // Reset after a found result
        do_search(2'b00, 32'hF000_0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 32, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired pos=%0d exp=done", rd_pos);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule